// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes as asynchronous serial frames on a single line that idles high. A one-byte holding register sits in front of a shift register. Software can therefore queue the next character while the current one is still leaving the pin. Characters pass back to back with no idle gap.

The block is controlled through five write-only register offsets. Three of them queue a byte, and each gives a different frame shape:
- a plain 8-bit frame;
- a frame with a ninth address bit forced to 1, for multidrop links;
- a frame with a second stop bit.

The other two offsets do the following:
- The status offset discards a pending byte and clears the interrupt flip-flop.
- The control offset holds an interrupt enable.

Bit timing comes from an external one-clock tick, issued once per bit period. Status is presented as direct outputs.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset `txd` is 1, and `buf_full`, `tx_busy` and `tx_irq` are 0. The line stays 1 whenever `tx_busy` is 0.
- R2: A write to offset 0, 1 or 2 stores `reg_wdata` in the holding register and sets `buf_full` from the next cycle on.
- R3: At the first `bit_tick` cycle that finds `buf_full` set and the shifter idle, the following all happen on the same edge: `txd` drops to 0 (start bit), `tx_busy` rises and `buf_full` clears. A byte written while `tick` is high starts on the next tick.
- R4: An offset-0 frame is sent as follows:
  - the start bit;
  - then the data bits, LSB first, one per tick;
  - then one stop bit of 1.
  `tx_busy` clears at the tick that ends the stop bit, which is 10 bit periods after the start.
- R5: An offset-1 frame places an extra address bit of value 1 after the data bits and before the stop bit, for 11 bit periods in total.
- R6: An offset-2 frame has two stop bits, for 11 bit periods in total.
- R7: A write to offset 3 clears the interrupt flip-flop and `buf_full` (the held byte is discarded). It does not alter `txd` or `tx_busy`.
- R8: The interrupt flip-flop sets when the held byte moves into the shift register (`buf_full` 1→0 by transfer).
- R9: The interrupt flip-flop sets when `tx_busy` falls with the holding register empty. If a byte is held at the end of a stop bit, its start bit follows on that same tick and `tx_busy` stays 1.
- R10: Bit 0 of a write to offset 4 is the interrupt enable. `tx_irq` equals the flip-flop gated by it, and the flip-flop keeps its state while disabled. The enable resets to 0.
- R11: `txd` changes only in the cycle after a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset (0 data, 1 address-bit data, 2 long-stop data, 3 status, 4 control) |
| reg_wdata | input | DATA_W | Write data |
| txd | output | 1 | Serial line, idle high |
| buf_full | output | 1 | Holding register occupied |
| tx_busy | output | 1 | Shift register sending a frame |
| tx_irq | output | 1 | Transmit interrupt request (enabled) |

## Verification
The bench builds the block with its default 8-bit data width and a tick every fourth clock. With these values it can sweep all 256 byte values through each of the three frame shapes, and compare every bit period against a frame word formed arithmetically from the byte and mode. Directed sequences then cover:
- the back-to-back hand-over at the stop-bit edge;
- discarding a held byte with a status write;
- a mid-frame interrupt clear followed by the idle interrupt;
- gating by the enable.

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              txd,
  output logic              buf_full,
  output logic              tx_busy,
  output logic              tx_irq
);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_ADRB = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_LONG = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4);
  localparam int SH_W  = DATA_W + 3;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic [DATA_W-1:0] hold_q;
  logic              hold_adr_q, hold_long_q, full_q;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              txd_q, busy_q, irq_q, ien_q;

  wire wr_byte   = reg_wr && (reg_addr == OFS_DATA || reg_addr == OFS_ADRB || reg_addr == OFS_LONG);
  wire wr_stat   = reg_wr && reg_addr == OFS_STAT;
  wire wr_ctrl   = reg_wr && reg_addr == OFS_CTRL;
  wire last_bit  = busy_q && cnt_q == '0;
  wire load      = bit_tick && full_q && (!busy_q || last_bit);
  wire shift     = bit_tick && busy_q && cnt_q != '0;
  wire frame_end = bit_tick && last_bit && !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_adr_q  <= 1'b0;
      hold_long_q <= 1'b0;
      full_q      <= 1'b0;
      sh_q        <= '1;
      cnt_q       <= '0;
      txd_q       <= 1'b1;
      busy_q      <= 1'b0;
      irq_q       <= 1'b0;
      ien_q       <= 1'b0;
    end else begin
      if (wr_byte) begin
        hold_q      <= reg_wdata;
        hold_adr_q  <= reg_addr == OFS_ADRB;
        hold_long_q <= reg_addr == OFS_LONG;
      end
      if (wr_stat)      full_q <= 1'b0;
      else if (wr_byte) full_q <= 1'b1;
      else if (load)    full_q <= 1'b0;

      if (load) begin
        txd_q  <= 1'b0;
        busy_q <= 1'b1;
        sh_q   <= {3'b111, hold_q};
        cnt_q  <= CNT_W'(DATA_W + 1) + CNT_W'(hold_adr_q) + CNT_W'(hold_long_q);
      end else if (shift) begin
        txd_q <= sh_q[0];
        sh_q  <= {1'b1, sh_q[SH_W-1:1]};
        cnt_q <= cnt_q - 1'b1;
      end else if (frame_end) begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end

      if (load || frame_end) irq_q <= 1'b1;
      else if (wr_stat)      irq_q <= 1'b0;

      if (wr_ctrl) ien_q <= reg_wdata[0];
    end
  end

  assign txd      = txd_q;
  assign buf_full = full_q;
  assign tx_busy  = busy_q;
  assign tx_irq   = irq_q & ien_q;

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_q);
  p_full_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> full_q);
  p_start_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (!txd_q && $past(full_q) && $past(bit_tick)));
  p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bit_tick) |=> (!full_q && !irq_q));
  p_load_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(full_q) && !$past(wr_stat)) |-> irq_q);
  p_idle_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> irq_q);
  p_txd_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd_q) |-> $past(bit_tick));
endmodule

// File: tb/sertx_dbuf_tb.sv
module sertx_dbuf_tb;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic txd, buf_full, tx_busy, tx_irq;
  int errors = 0, checks = 0;

  sertx_dbuf #(.DATA_W(DW), .ADDR_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .txd(txd),
    .buf_full(buf_full), .tx_busy(tx_busy), .tx_irq(tx_irq));

  always #5 clk = ~clk;

  initial forever begin
    repeat (3) @(posedge clk);
    #2 bit_tick = 1'b1;
    @(posedge clk);
    #2 bit_tick = 1'b0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic next_bit();
    while (!bit_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && tx_busy; i++) next_bit();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R4: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nb, bad;
    logic [DW-1:0] b;
    repeat (4) @(negedge clk);
    chk("R1 txd", txd, 1); chk("R1 full", buf_full, 0);
    chk("R1 busy", tx_busy, 0); chk("R1 irq", tx_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(3'd4, 8'h01);

    for (int m = 0; m < 3; m++) begin
      for (int v = 0; v < 256; v++) begin
        b = DW'(v);
        nb = DW + 1 + ((m != 0) ? 1 : 0);
        wr(3'd3, 8'h00);
        if (v == 0) chk("R7 irq cleared", tx_irq, 0);
        wr(3'(m), b);
        chk("R2 full after write", buf_full, 1);
        next_bit();
        chk("R3 start bit", txd, 0); chk("R3 busy", tx_busy, 1);
        chk("R3 full cleared", buf_full, 0);
        chk("R8 irq on transfer", tx_irq, 1);
        bad = 0;
        for (int k = 0; k < nb; k++) begin
          next_bit();
          if (txd !== ((k < DW) ? b[k] : 1'b1)) bad++;
        end
        chk("R11 busy through last bit", tx_busy, 1);
        if (m == 0) chk("R4 frame bits", bad, 0);
        else if (m == 1) chk("R5 address-bit frame", bad, 0);
        else chk("R6 long-stop frame", bad, 0);
        next_bit();
        chk("R4 busy clears after stop", tx_busy, 0);
        chk("R1 idle line", txd, 1);
      end
    end

    wr(3'd3, 8'h00);
    wr(3'd0, 8'h5A);
    next_bit();
    wr(3'd3, 8'h00);
    chk("R7 irq cleared mid-frame", tx_irq, 0);
    chk("R7 busy unaffected", tx_busy, 1);
    drain();
    chk("R9 irq on idle with empty buffer", tx_irq, 1);

    wr(3'd3, 8'h00);
    wr(3'd0, 8'hA5);
    next_bit();
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h3C);
    chk("R2 second byte held", buf_full, 1);
    for (int k = 0; k < DW + 1; k++) next_bit();
    next_bit();
    chk("R9 back-to-back busy held", tx_busy, 1);
    chk("R9 back-to-back start bit", txd, 0);
    chk("R8 back-to-back transfer irq", tx_irq, 1);
    drain();

    wr(3'd3, 8'h00);
    next_bit();
    wr(3'd0, 8'hFF);
    wr(3'd3, 8'h00);
    chk("R7 held byte discarded", buf_full, 0);
    chk("R7 no irq from discard", tx_irq, 0);
    next_bit();
    chk("R7 no frame starts", tx_busy, 0);
    chk("R7 line stays idle", txd, 1);

    wr(3'd4, 8'h00);
    wr(3'd0, 8'h11);
    next_bit();
    chk("R10 irq gated off", tx_irq, 0);
    wr(3'd4, 8'h01);
    chk("R10 irq kept and shown", tx_irq, 1);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule